// File: doc/BRIEF.md
# PCM Serial Data Port with Power Sequencing

This block is the digital framing and serial-data engine of one telephony PCM channel. On the transmit side it holds the 8-bit word produced by the encoder. After each transmit frame sync it shifts the word out most significant bit first, on a data output that can be tri-stated. On the receive side it collects eight serial bits after each receive frame sync and presents them as a parallel word with a one-cycle valid strobe.

All pins are oversampled by a single fast system clock. The system clock must be synchronous to the master clock and must run at least twice as fast as any bit clock. Frame syncs are sampled on falling bit-clock edges, transmit bits change on rising edges, and receive bits are taken on falling edges.

A combined master-clock/power-down pin controls power. Holding it low, or toggling it, keeps the block powered. Holding it at a steady high powers the block down. After every power-up, the data output stays disabled until the second transmit frame sync.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset the block is powered down: `sd_oe_o`=0, `aout_en_o`=0, `rx_valid_o`=0.
- R2: A low level on `pd_mclk_i`, or any change of its level, makes `aout_en_o` 1 from the next cycle on. A high level held for `PD_HOLD` consecutive cycles (default 32) makes it 0.
- R3: While powered down, `sd_oe_o` is 0, including when power is lost in the middle of a frame. Power-down also clears the count of frame syncs seen, so after the next power-up two more transmit frame syncs are needed before the output drives.
- R4: After power-up the first transmit frame sync produces no drive. The second and every later one do.
- R5: The word driven in a frame is the `tx_word_i` value sampled at the start of the previous transmit frame. It is sent MSB first, one bit per rising edge of `bclk_tx_i`.
- R6: `sd_oe_o` rises on the first rising bit-clock edge after a driven frame start. It falls on the ninth rising edge, unless a new frame has started at the eighth falling edge; in that case it stays high.
- R7: A frame starts at a falling bit-clock edge where the frame sync is 1 and was 0 at the previous falling edge. A sync held high across several falling edges starts only one frame.
- R8: After a receive frame start, `sd_i` is sampled on the next eight falling edges, MSB first. On the eighth of them `rx_word_o` is updated and `rx_valid_o` is 1 for exactly one cycle.
- R9: The receive side uses the edges of `bclk_rx_i` while that pin has changed within the last `ACT_WIN` cycles (default 32). Otherwise it uses `bclk_tx_i`.
- R10: While powered down, receive frames produce no `rx_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Power-on reset, active low |
| pd_mclk_i | input | 1 | Receive master clock / power-down level |
| bclk_tx_i | input | 1 | Transmit bit clock |
| bclk_rx_i | input | 1 | Receive bit clock (may be idle) |
| fs_tx_i | input | 1 | Transmit frame sync |
| fs_rx_i | input | 1 | Receive frame sync |
| tx_word_i | input | WORD_W | Encoder word to send |
| sd_i | input | 1 | Serial receive data |
| sd_o | output | 1 | Serial transmit data |
| sd_oe_o | output | 1 | Enable of the serial output driver |
| aout_en_o | output | 1 | Enable for the analog output stage (0 = high impedance) |
| rx_word_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe when `rx_word_o` is updated |

## Verification
With back-to-back frames, the receive side has to finish a word and open the next capture on the same falling edge. On that same edge the transmit side loads its next word while its enable must not drop. The bench provokes this by raising both frame syncs during the last bit of one frame, so that the eighth falling edge is also the next frame start. It then checks three things: the first word arrives with its single strobe, the second word is still captured, and `sd_oe_o` stays high across the seam with the correct next bit. A second overlap, power loss in the middle of a driven frame, is provoked by raising the power-down level after the first bit; it is judged by the output going quiet and by the next power-up needing two new syncs.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  function automatic logic [1:0] sync_sat_inc(input logic [1:0] n);
    return (n == 2'd2) ? n : n + 2'd1;
  endfunction

  function automatic logic frame_open(input logic fall, input logic fs_now,
                                      input logic fs_prev);
    return fall & fs_now & ~fs_prev;
  endfunction

endpackage

// File: rtl/pcm_clk_watch.sv
module pcm_clk_watch
  import pcm_port_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin_i,
  output edge_t edge_o
);

  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_i;
  end

  assign edge_o.rise = pin_i & ~pin_q;
  assign edge_o.fall = ~pin_i & pin_q;

endmodule

// File: rtl/pcm_pwr_seq.sv
module pcm_pwr_seq #(
  parameter int PD_HOLD = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pwr_up_o
);

  localparam int CW = $clog2(PD_HOLD + 1);
  localparam logic [CW-1:0] FULL = CW'(PD_HOLD);

  logic          pin_q;
  logic [CW-1:0] hi_cnt;
  logic          pin_moved;

  function automatic logic [CW-1:0] hold_step(input logic [CW-1:0] c,
                                              input logic pin, input logic moved);
    if (!pin || moved) return '0;
    if (c == FULL)     return c;
    return c + CW'(1);
  endfunction

  assign pin_moved = pin_i ^ pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b1;
      hi_cnt <= FULL;
    end else begin
      pin_q  <= pin_i;
      hi_cnt <= hold_step(hi_cnt, pin_i, pin_moved);
    end
  end

  assign pwr_up_o = (hi_cnt != FULL);

  a_r2_low_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_i |=> pwr_up_o);

  a_r2_toggle_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    pin_moved |=> pwr_up_o);

  a_r2_hold_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_i && !pin_moved && hi_cnt == FULL - CW'(1)) |=> !pwr_up_o);

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_up_i,
  input  edge_t        bclk_e_i,
  input  logic         fs_i,
  input  logic [W-1:0] word_i,
  output logic         sd_o,
  output logic         oe_o
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] NBITS = CW'(W);

  logic          fs_prev_q;
  logic [1:0]    fs_seen_q;
  logic [W-1:0]  pend_q;
  logic [W-1:0]  sh_q;
  logic [CW-1:0] left_q;
  logic          armed_q;
  logic          start_w;

  function automatic logic [W-1:0] shift_up(input logic [W-1:0] v);
    return {v[W-2:0], 1'b0};
  endfunction

  assign start_w = frame_open(bclk_e_i.fall, fs_i, fs_prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             fs_prev_q <= 1'b0;
    else if (bclk_e_i.fall) fs_prev_q <= fs_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_seen_q <= 2'd0;
      pend_q    <= '0;
      sh_q      <= '0;
      left_q    <= '0;
      armed_q   <= 1'b0;
      sd_o      <= 1'b0;
      oe_o      <= 1'b0;
    end else if (!pwr_up_i) begin
      fs_seen_q <= 2'd0;
      left_q    <= '0;
      armed_q   <= 1'b0;
      sd_o      <= 1'b0;
      oe_o      <= 1'b0;
    end else if (start_w) begin
      sh_q      <= pend_q;
      pend_q    <= word_i;
      left_q    <= NBITS;
      armed_q   <= (fs_seen_q != 2'd0);
      fs_seen_q <= sync_sat_inc(fs_seen_q);
    end else if (bclk_e_i.rise) begin
      if (left_q != '0) begin
        left_q <= left_q - CW'(1);
        sh_q   <= shift_up(sh_q);
        if (armed_q) begin
          oe_o <= 1'b1;
          sd_o <= sh_q[W-1];
        end
      end else begin
        oe_o <= 1'b0;
      end
    end
  end

  a_r3_down_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up_i |=> !oe_o);

  a_r4_second_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> (fs_seen_q == 2'd2));

  a_r5_msb_out: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up_i && bclk_e_i.rise && armed_q && left_q != '0) |=> (sd_o == $past(sh_q[W-1])));

  a_r6_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_e_i.rise && left_q == '0) |=> !oe_o);

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_up_i,
  input  logic         fall_i,
  input  logic         fs_i,
  input  logic         sd_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] NBITS = CW'(W);

  logic          fs_prev_q;
  logic [W-1:0]  sh_q;
  logic [CW-1:0] left_q;
  logic          start_w;
  logic          last_bit_w;

  function automatic logic [W-1:0] push_lsb(input logic [W-1:0] v, input logic b);
    return {v[W-2:0], b};
  endfunction

  assign start_w    = frame_open(fall_i, fs_i, fs_prev_q);
  assign last_bit_w = fall_i && (left_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fs_prev_q <= 1'b0;
    else if (fall_i) fs_prev_q <= fs_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      left_q  <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else if (!pwr_up_i) begin
      left_q  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (fall_i) begin
        if (left_q != '0) begin
          sh_q   <= push_lsb(sh_q, sd_i);
          left_q <= left_q - CW'(1);
          if (last_bit_w) begin
            word_o  <= push_lsb(sh_q, sd_i);
            valid_o <= 1'b1;
          end
        end
        if (start_w) left_q <= NBITS;
      end
    end
  end

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  a_r8_strobe_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up_i && last_bit_w) |=> valid_o);

  a_r10_down_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up_i |=> !valid_o);

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int PD_HOLD = 32,
  parameter int ACT_WIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_mclk_i,
  input  logic              bclk_tx_i,
  input  logic              bclk_rx_i,
  input  logic              fs_tx_i,
  input  logic              fs_rx_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              sd_i,
  output logic              sd_o,
  output logic              sd_oe_o,
  output logic              aout_en_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o
);

  localparam int AW = $clog2(ACT_WIN + 1);
  localparam logic [AW-1:0] ACT_FULL = AW'(ACT_WIN);

  edge_t         tx_e;
  edge_t         rx_e;
  logic          pwr_up;
  logic [AW-1:0] act_cnt_q;
  logic          rx_running;
  logic          sel_fall;

  pcm_pwr_seq #(.PD_HOLD(PD_HOLD)) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (pd_mclk_i),
    .pwr_up_o (pwr_up)
  );

  pcm_clk_watch u_txclk (.clk(clk), .rst_n(rst_n), .pin_i(bclk_tx_i), .edge_o(tx_e));
  pcm_clk_watch u_rxclk (.clk(clk), .rst_n(rst_n), .pin_i(bclk_rx_i), .edge_o(rx_e));

  function automatic logic [AW-1:0] act_step(input logic [AW-1:0] c, input logic seen);
    if (seen)          return '0;
    if (c == ACT_FULL) return c;
    return c + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_cnt_q <= ACT_FULL;
    else        act_cnt_q <= act_step(act_cnt_q, rx_e.rise | rx_e.fall);
  end

  assign rx_running = (act_cnt_q != ACT_FULL);
  assign sel_fall   = rx_running ? rx_e.fall : tx_e.fall;

  pcm_tx_lane #(.W(WORD_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_up_i (pwr_up),
    .bclk_e_i (tx_e),
    .fs_i     (fs_tx_i),
    .word_i   (tx_word_i),
    .sd_o     (sd_o),
    .oe_o     (sd_oe_o)
  );

  pcm_rx_lane #(.W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_up_i (pwr_up),
    .fall_i   (sel_fall),
    .fs_i     (fs_rx_i),
    .sd_i     (sd_i),
    .word_o   (rx_word_o),
    .valid_o  (rx_valid_o)
  );

  assign aout_en_o = pwr_up;

  a_r9_rx_edge_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_e.rise || rx_e.fall) |=> rx_running);

  a_r3_output_off: assert property (@(posedge clk) disable iff (!rst_n)
    !aout_en_o |=> !sd_oe_o);

endmodule

// File: tb/pcm_serial_port_tb.sv
`timescale 1ns/1ps
module pcm_serial_port_tb_top;

  localparam int W = 8, PD_HOLD = 32, ACT_WIN = 32, HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pd_lvl = 1'b1, pd_tog = 1'b0, tog_q = 1'b0;
  logic bclk_t = 1'b0, bclk_r = 1'b0, fs = 1'b0, sd_in = 1'b0;
  logic [W-1:0] txw = '0;
  wire  pd_pin = pd_tog ? tog_q : pd_lvl;

  logic sd_o, sd_oe_o, aout_en_o, rx_valid_o;
  logic [W-1:0] rx_word_o;

  int checks = 0, fails = 0, vcnt = 0, tcnt = 0;
  logic [W-1:0] vlast = '0;
  bit done = 0;

  always #2 clk = ~clk;

  pcm_serial_port #(.WORD_W(W), .PD_HOLD(PD_HOLD), .ACT_WIN(ACT_WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .pd_mclk_i(pd_pin), .bclk_tx_i(bclk_t),
    .bclk_rx_i(bclk_r), .fs_tx_i(fs), .fs_rx_i(fs), .tx_word_i(txw),
    .sd_i(sd_in), .sd_o(sd_o), .sd_oe_o(sd_oe_o), .aout_en_o(aout_en_o),
    .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o)
  );

  always @(negedge clk) begin
    tcnt = tcnt + 1;
    if (pd_tog && (tcnt % 4 == 0)) tog_q = ~tog_q;
    if (rx_valid_o) begin
      vcnt  = vcnt + 1;
      vlast = rx_word_o;
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hi(input bit ten, input bit ren);
    if (ten) bclk_t = 1'b1;
    if (ren) bclk_r = 1'b1;
    wait_n(HALF);
  endtask

  task automatic lo(input bit ten, input bit ren);
    if (ten) bclk_t = 1'b0;
    if (ren) bclk_r = 1'b0;
    wait_n(HALF);
  endtask

  task automatic frame(input logic [W-1:0] tw, input logic [W-1:0] rw,
                       input bit ten, input bit ren, input bit chain_in,
                       input bit chain_out, input logic [W-1:0] nxt,
                       input bit fs_long, input bit exp_drv,
                       input logic [W-1:0] exp_w, input bit exp_rx, input string rq);
    int v0 = vcnt;
    if (!chain_in) begin
      txw = tw;
      fs  = 1'b1;
      hi(ten, ren);
      lo(ten, ren);
    end
    if (!fs_long) fs = 1'b0;
    for (int i = 0; i < W; i++) begin
      sd_in = rw[W-1-i];
      hi(ten, ren);
      chk(rq, "drive enable", {31'd0, sd_oe_o}, {31'd0, exp_drv});
      if (exp_drv) chk(rq, "serial bit", {31'd0, sd_o}, {31'd0, exp_w[W-1-i]});
      if (i == W - 1 && chain_out) begin
        fs  = 1'b1;
        txw = nxt;
      end
      lo(ten, ren);
      if (i == 0 && fs_long) fs = 1'b0;
    end
    chk(rq, "rx strobes", vcnt - v0, exp_rx ? 1 : 0);
    if (exp_rx) chk(rq, "rx word", {24'd0, vlast}, {24'd0, rw});
  endtask

  task automatic tail(input string rq);
    hi(1'b1, 1'b0);
    chk(rq, "enable after 8 bits", {31'd0, sd_oe_o}, 32'd0);
    lo(1'b1, 1'b0);
  endtask

  task automatic t_reset();
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    chk("R1", "sd_oe", {31'd0, sd_oe_o}, 32'd0);
    chk("R1", "aout_en", {31'd0, aout_en_o}, 32'd0);
    chk("R1", "rx_valid", {31'd0, rx_valid_o}, 32'd0);
  endtask

  task automatic t_wake_low();
    pd_lvl = 1'b0;
    wait_n(2);
    chk("R2", "aout_en after low", {31'd0, aout_en_o}, 32'd1);
  endtask

  task automatic t_first_frames();
    frame(8'hA5, 8'h5A, 1, 0, 0, 0, 8'h00, 0, 0, 8'h00, 1, "R4/R8");
    frame(8'h3C, 8'hC3, 1, 0, 0, 0, 8'h00, 1, 1, 8'hA5, 1, "R5/R7");
    tail("R6");
  endtask

  task automatic t_back_to_back();
    frame(8'h81, 8'h7E, 1, 0, 0, 1, 8'hE7, 0, 1, 8'h3C, 1, "R6 seam a");
    frame(8'h00, 8'h18, 1, 0, 1, 0, 8'h00, 0, 1, 8'h81, 1, "R8 seam b");
    tail("R6");
  endtask

  task automatic t_rx_clock_only();
    frame(8'h00, 8'h96, 0, 1, 0, 0, 8'h00, 0, 0, 8'h00, 1, "R9 rx clock");
    wait_n(ACT_WIN + 8);
  endtask

  task automatic t_power_loss();
    txw = 8'h42;
    fs  = 1'b1;
    hi(1, 0);
    lo(1, 0);
    fs  = 1'b0;
    hi(1, 0);
    chk("R3", "driving before loss", {31'd0, sd_oe_o}, 32'd1);
    chk("R5", "first bit of E7", {31'd0, sd_o}, 32'd1);
    pd_lvl = 1'b1;
    wait_n(PD_HOLD + 4);
    chk("R3", "enable after loss", {31'd0, sd_oe_o}, 32'd0);
    chk("R3", "aout after loss", {31'd0, aout_en_o}, 32'd0);
    lo(1, 0);
    frame(8'h55, 8'hF0, 1, 0, 0, 0, 8'h00, 0, 0, 8'h00, 0, "R10");
  endtask

  task automatic t_wake_toggle();
    pd_tog = 1'b1;
    wait_n(40);
    chk("R2", "aout_en while toggling", {31'd0, aout_en_o}, 32'd1);
    frame(8'h11, 8'h22, 1, 0, 0, 0, 8'h00, 0, 0, 8'h00, 1, "R3 recount");
    frame(8'h99, 8'h33, 1, 0, 0, 0, 8'h00, 0, 1, 8'h11, 1, "R4 second");
    tail("R6");
  endtask

  task automatic t_steady_high();
    pd_tog = 1'b0;
    pd_lvl = 1'b1;
    wait_n(8);
    chk("R2", "aout_en short high", {31'd0, aout_en_o}, 32'd1);
    wait_n(PD_HOLD);
    chk("R2", "aout_en long high", {31'd0, aout_en_o}, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_wake_low();
    t_first_frames();
    t_back_to_back();
    t_rx_clock_only();
    t_power_loss();
    t_wake_toggle();
    t_steady_high();
    finish_run();
  end

  initial begin
    #(4 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

endmodule